// File: doc/BRIEF.md
# Square-Matrix Recency Tracker for a Four-Way Set

This block keeps the use order of the ways of one associative set and names the way to evict on the next miss. Recency lives in a square bit matrix with one row and one column per way. A single access updates the matrix in one clock cycle. The oldest way is the row that holds no ones. The same tracker serves a fully associative cache, one set of a set-associative cache, or a small page-frame pool.

The access input is a plain control strobe, not a stream. There is no back-pressure: every cycle with `acc_valid` high is taken. `victim_way` is combinational from stored state, so it shows the result of an access one clock edge after that access is sampled. A way counts as filled from its first access after reset. Until every way is filled, the victim is the lowest unfilled way. After that, the matrix picks it.

Top module: `lru_matrix_tracker`

## Requirements
- R1: While reset is asserted and right after it is released, every matrix bit is 0, no way counts as filled, and `victim_way` is 0.
- R2: On a clock edge with `acc_valid` high and `acc_way` = k, every bit of row k except bit (k,k) becomes 1. Matrix bit (r,c) appears on `matrix_view[r*WAYS+c]`.
- R3: On that same edge, every bit of column k becomes 0 in every row.
- R4: The diagonal bits (i,i) are 0 at all times.
- R5: On a clock edge with `acc_valid` low, the matrix and the set of filled ways do not change, whatever `acc_way` carries.
- R6: While at least one way has not been accessed since reset, `victim_way` is the lowest-numbered such way.
- R7: Once all ways have been accessed, `victim_way` is the lowest-numbered way whose matrix row is all zeros, which is the least recently accessed way.
- R8: After any accepted access, `victim_way` never names the way just accessed. It reflects that access from the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Access strobe; one access per high cycle |
| acc_way | input | $clog2(WAYS) | Index of the way being accessed |
| victim_way | output | $clog2(WAYS) | Way to replace on the next miss |
| matrix_view | output | WAYS*WAYS | Debug view of the recency matrix, bit r*WAYS+c is row r, column c |

## Verification
A corrupted matrix bit shows up on `matrix_view` at the edge after the faulty update. It also reaches `victim_way` as soon as that bit changes which row is all zeros. A lost fill flag shows up differently: the victim stays on an already used way while the set is still filling. That is visible on the very next access. The bench replays a fill-then-evict history and compares the victim after every step. It also checks the matrix against a model built from the row-set and column-clear rules, so a wrong bit cannot stay hidden for more than one cycle.

// File: rtl/lru_pkg.sv
package lru_pkg;
  // Source of the victim index
  typedef enum logic {
    PICK_FREE = 1'b0,
    PICK_LRU  = 1'b1
  } pick_e;
endpackage

// File: rtl/lru_matrix_row.sv
// One row of the recency matrix: set on own access, clear one column on others.
module lru_matrix_row #(
  parameter int WAYS = 4,
  parameter int ROW  = 0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      upd,
  input  logic [$clog2(WAYS)-1:0]   upd_way,
  output logic [WAYS-1:0]           row_q
);
  localparam int IDX_W = $clog2(WAYS);
  localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(ROW);
  localparam logic [WAYS-1:0]  SELF   = WAYS'(1) << ROW;

  logic [WAYS-1:0] col_mask;
  assign col_mask = WAYS'(1) << upd_way;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
    end else if (upd) begin
      if (upd_way == MY_IDX) begin
        row_q <= ~SELF;
      end else begin
        row_q <= row_q & ~col_mask;
      end
    end
  end
endmodule

// File: rtl/lru_fill_track.sv
// Remembers which ways have been touched since reset; finds the lowest free one.
module lru_fill_track #(
  parameter int WAYS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd,
  input  logic [$clog2(WAYS)-1:0] upd_way,
  output logic                    any_free,
  output logic [$clog2(WAYS)-1:0] free_idx
);
  localparam int IDX_W = $clog2(WAYS);

  logic [WAYS-1:0] filled_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filled_q <= '0;
    end else if (upd) begin
      filled_q <= filled_q | (WAYS'(1) << upd_way);
    end
  end

  assign any_free = ~&filled_q;

  always_comb begin
    free_idx = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!filled_q[i]) free_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/lru_victim_pick.sv
// Chooses the replacement way: free way first, otherwise lowest all-zero row.
module lru_victim_pick
  import lru_pkg::*;
#(
  parameter int WAYS = 4
) (
  input  logic [WAYS*WAYS-1:0]    rows,
  input  logic                    any_free,
  input  logic [$clog2(WAYS)-1:0] free_idx,
  output logic [$clog2(WAYS)-1:0] victim
);
  localparam int IDX_W = $clog2(WAYS);

  logic [WAYS-1:0]  row_zero;
  logic [IDX_W-1:0] lru_idx;
  pick_e            src;

  for (genvar g = 0; g < WAYS; g++) begin : g_zero
    assign row_zero[g] = ~|rows[g*WAYS +: WAYS];
  end

  always_comb begin
    lru_idx = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (row_zero[i]) lru_idx = IDX_W'(i);
    end
  end

  assign src    = any_free ? PICK_FREE : PICK_LRU;
  assign victim = (src == PICK_FREE) ? free_idx : lru_idx;
endmodule

// File: rtl/lru_matrix_tracker.sv
module lru_matrix_tracker #(
  parameter int WAYS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_valid,
  input  logic [$clog2(WAYS)-1:0] acc_way,
  output logic [$clog2(WAYS)-1:0] victim_way,
  output logic [WAYS*WAYS-1:0]    matrix_view
);
  localparam int IDX_W = $clog2(WAYS);

  logic [WAYS*WAYS-1:0] rows_flat;
  logic                 any_free;
  logic [IDX_W-1:0]     free_idx;

  for (genvar r = 0; r < WAYS; r++) begin : g_row
    lru_matrix_row #(.WAYS(WAYS), .ROW(r)) u_row (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd     (acc_valid),
      .upd_way (acc_way),
      .row_q   (rows_flat[r*WAYS +: WAYS])
    );
  end

  lru_fill_track #(.WAYS(WAYS)) u_fill (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (acc_valid),
    .upd_way  (acc_way),
    .any_free (any_free),
    .free_idx (free_idx)
  );

  lru_victim_pick #(.WAYS(WAYS)) u_pick (
    .rows     (rows_flat),
    .any_free (any_free),
    .free_idx (free_idx),
    .victim   (victim_way)
  );

  assign matrix_view = rows_flat;
endmodule

// File: rtl/lru_matrix_chk.sv
module lru_matrix_chk #(
  parameter int WAYS = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    acc_valid,
  input logic [$clog2(WAYS)-1:0] acc_way,
  input logic [$clog2(WAYS)-1:0] victim_way,
  input logic [WAYS*WAYS-1:0]    matrix_view
);
  function automatic logic [WAYS-1:0] row_of(logic [WAYS*WAYS-1:0] m, int r);
    return m[r*WAYS +: WAYS];
  endfunction

  function automatic logic [WAYS-1:0] col_of(logic [WAYS*WAYS-1:0] m, int c);
    logic [WAYS-1:0] v;
    for (int r = 0; r < WAYS; r++) v[r] = m[r*WAYS + c];
    return v;
  endfunction

  function automatic logic [WAYS-1:0] diag_of(logic [WAYS*WAYS-1:0] m);
    logic [WAYS-1:0] v;
    for (int i = 0; i < WAYS; i++) v[i] = m[i*WAYS + i];
    return v;
  endfunction

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (matrix_view == '0 && victim_way == '0)); // R1

  AST_ROW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> row_of(matrix_view, int'($past(acc_way))) ==
                  ~(WAYS'(1) << $past(acc_way))); // R2

  AST_COL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> col_of(matrix_view, int'($past(acc_way))) == '0); // R3

  AST_DIAG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    diag_of(matrix_view) == '0); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> $stable(matrix_view)); // R5

  AST_VICTIM_NOT_MRU: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> victim_way != $past(acc_way)); // R8
endmodule

bind lru_matrix_tracker lru_matrix_chk #(.WAYS(WAYS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid   (acc_valid),
  .acc_way     (acc_way),
  .victim_way  (victim_way),
  .matrix_view (matrix_view)
);

// File: tb/sim_lru_matrix_tracker.sv
`timescale 1ns/1ps
module sim_lru_matrix_tracker;
  localparam int WAYS = 4;
  localparam int NVEC = 12;
  // {acc_valid, acc_way[1:0], expected victim[1:0]}
  localparam logic [4:0] VEC [NVEC] = '{
    {1'b1, 2'd0, 2'd1},  // fill way 0, free way 1 is victim (R6)
    {1'b1, 2'd2, 2'd1},  // R6
    {1'b1, 2'd3, 2'd1},  // R6
    {1'b1, 2'd1, 2'd0},  // set full, LRU is 0 (R7)
    {1'b0, 2'd3, 2'd0},  // idle, way field ignored (R5)
    {1'b1, 2'd0, 2'd2},  // replace 0, LRU becomes 2 (R7)
    {1'b1, 2'd2, 2'd3},  // replace 2 (R7)
    {1'b1, 2'd2, 2'd3},  // repeat same way (R2)
    {1'b1, 2'd3, 2'd1},  // R7
    {1'b0, 2'd0, 2'd1},  // idle again (R5)
    {1'b1, 2'd1, 2'd0},  // R7
    {1'b1, 2'd0, 2'd2}   // R7
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_way = '0;
  logic [1:0]  victim_way;
  logic [15:0] matrix_view;

  int checks = 0;
  int failures = 0;
  logic [15:0] model;

  always #4 clk = ~clk;

  lru_matrix_tracker #(.WAYS(WAYS)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_way(acc_way),
    .victim_way(victim_way), .matrix_view(matrix_view)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_step(logic [15:0] m, logic [1:0] w);
    logic [15:0] n = m;
    for (int c = 0; c < WAYS; c++) n[int'(w)*WAYS + c] = 1'b1;
    for (int r = 0; r < WAYS; r++) n[r*WAYS + int'(w)] = 1'b0;
    return n;
  endfunction

  function automatic logic [15:0] diag(logic [15:0] m);
    logic [15:0] d = '0;
    for (int i = 0; i < WAYS; i++) d[i] = m[i*WAYS + i];
    return d;
  endfunction

  task automatic step(input logic v, input logic [1:0] w);
    acc_valid = v;
    acc_way = w;
    if (v) model = model_step(model, w);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures + 0);
    $finish;
  end

  initial begin
    model = '0;
    repeat (3) @(negedge clk);
    check("R1 reset matrix", matrix_view, 16'h0);
    check("R1 reset victim", {14'd0, victim_way}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", matrix_view, 16'h0);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][4], VEC[i][3:2]);
      check(VEC[i][4] ? "R7/R6 victim" : "R5 idle victim",
            {14'd0, victim_way}, {14'd0, VEC[i][1:0]});
      check("R2/R3/R5 matrix", matrix_view, model);
      check("R4 diagonal", diag(matrix_view), 16'h0);
      if (VEC[i][4])
        check("R8 victim differs from MRU",
              {15'd0, victim_way == VEC[i][3:2]}, 16'd0);
    end

    // Reset in the middle of use clears everything again (R1)
    rst_n = 1'b0;
    model = '0;
    @(negedge clk);
    check("R1 mid reset matrix", matrix_view, 16'h0);
    check("R1 mid reset victim", {14'd0, victim_way}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Partial fill out of order (R6)
    step(1'b1, 2'd1);
    check("R6 free way 0", {14'd0, victim_way}, 16'd0);
    step(1'b1, 2'd0);
    check("R6 free way 2", {14'd0, victim_way}, 16'd2);
    // Idle with valid low must not fill way 2 (R5)
    step(1'b0, 2'd2);
    check("R5 idle no fill", {14'd0, victim_way}, 16'd2);
    check("R5 idle matrix", matrix_view, model);
    step(1'b1, 2'd2);
    check("R6 free way 3", {14'd0, victim_way}, 16'd3);
    step(1'b1, 2'd3);
    // Order now 1,0,2,3: LRU is way 1 (R7)
    check("R7 LRU after fill", {14'd0, victim_way}, 16'd1);
    check("R2 R3 matrix after fill", matrix_view, model);
    // Back-to-back hits on way 1 then way 0 (R7, R8)
    step(1'b1, 2'd1);
    check("R7 LRU way 0", {14'd0, victim_way}, 16'd0);
    step(1'b1, 2'd0);
    check("R7 LRU way 2", {14'd0, victim_way}, 16'd2);
    check("R4 diagonal end", diag(matrix_view), 16'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule